// File: doc/BRIEF.md
# Four-Bit Stored-Program Accumulator Processor

This block is a very small stored-program processor. Its data path is four bits wide. A sixteen-word by four-bit RAM holds both the program and its data. A program counter addresses that RAM, and an instruction register captures each opcode as it is fetched. Two working registers (A and B) and a visible output register complete the data path. A sequencer reads the captured opcode and steps through fetch and execute. Instructions that name a memory location take a second RAM word as their address operand, so an instruction is either one or two words long.

The RAM is filled through a programming port. While the program-mode input is high, each strobe writes one word to the given address, and the sequencer is frozen. When program mode is dropped, the processor runs from the word its counter holds. It keeps running until it reaches a halt instruction. After that, only a reset starts it again, and the reset leaves the RAM contents in place.

The sequencer has four states. FETCH captures an opcode from RAM at the counter. OPERAND captures the address word that follows a two-word opcode. EXECUTE performs the operation. HALTED is terminal. The transitions are:
- FETCH to OPERAND for LDA, STA and JMP.
- FETCH to EXECUTE for every other opcode.
- OPERAND to EXECUTE.
- EXECUTE to FETCH, or EXECUTE to HALTED for HLT.
- HALTED to itself until reset.

Program mode holds the current state. Reset enters FETCH.

Top module: `nib_cpu`

## Requirements
- R1: After reset, the counter is 0000, A, B and the output are 0000, the halted flag is low, and execution begins at address 0000 once program mode is low.
- R2: With RAM holding 1,8,6,1,9,2,7,5,5,3 and then zeros, the program ends with the output equal to 1000 and the halted flag high.
- R3: ADD (code 0010) sets A to A+B modulo 16, and the carry is dropped.
- R4: LDA (code 0001, operand word = address) loads A from RAM at that address. STA (code 0011, operand word = address) writes A to RAM at that address. A later LDA of the same address reads the stored value.
- R5: JMP (code 0100, operand word = target) continues execution at the target, and the words between are not executed.
- R6: The two-word opcodes are LDA, STA and JMP. For these, the word after the opcode is the operand, and the counter steps past it. The counter steps by one per fetched word and wraps from 1111 to 0000, including during an operand fetch. The instruction register changes only in FETCH.
- R7: Code 0000 (NOP) and the unassigned codes 1000 to 1111 are one-word instructions with no effect.
- R8: HLT (code 0101) raises the halted flag. The flag, the output and the counter then stay fixed until reset.
- R9: While program mode is high, a write strobe stores the data word at the given address, and no instruction makes progress. The counter, A, B and the output hold. When program mode drops, execution resumes from the point where it was frozen.
- R10: A reset while halted clears the counter, the registers, the output and the flag, and the RAM contents are kept.
- R11: MOV B,A (code 0110) copies A into B. MOV OUT,A (code 0111) copies A to the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| prog_en | input | 1 | Program mode: freezes the sequencer and routes RAM writes to the programming port |
| prog_addr | input | 4 | RAM address for a programming write |
| prog_data | input | 4 | Word written during programming |
| prog_we | input | 1 | Programming write strobe, one word per rising edge |
| out_val | output | 4 | Output register value |
| halted | output | 1 | High once HLT has executed, until reset |

## Verification
Only the output register and the halted flag are visible at the ports, so a wrong internal state has to be inferred from them. A bad counter step, a mishandled operand word or a faulty jump sends the program off its path. This shows as an unexpected output value, as no output change where one is due, or as a halt that arrives late or never. This usually appears within a few instructions of the fault. Each program is built so that a wrong path produces a distinct, wrong output value. A scoreboard compares every change of the output against the queued expectation.

// File: rtl/nib_cpu_pkg.sv
package nib_cpu_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'h0,
        OP_LDA    = 4'h1,
        OP_ADD    = 4'h2,
        OP_STA    = 4'h3,
        OP_JMP    = 4'h4,
        OP_HLT    = 4'h5,
        OP_MOVB   = 4'h6,
        OP_MOVOUT = 4'h7
    } opcode_e;

    typedef enum logic [1:0] {
        ST_FETCH,
        ST_OPER,
        ST_EXEC,
        ST_HALT
    } seq_state_e;

    typedef struct packed {
        logic ir_load;
        logic opr_load;
        logic pc_inc;
        logic pc_jump;
        logic addr_opr;
        logic a_from_mem;
        logic a_add;
        logic b_from_a;
        logic out_from_a;
        logic mem_we;
    } ctrl_t;

    function automatic logic needs_operand(input logic [3:0] op);
        return (op == OP_LDA) || (op == OP_STA) || (op == OP_JMP);
    endfunction

endpackage

// File: rtl/nib_ram.sv
module nib_ram #(
    parameter int W     = 4,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/nib_seq.sv
module nib_seq
    import nib_cpu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prog_en,
    input  logic [W-1:0] mem_word,
    input  logic [W-1:0] ir_word,
    output ctrl_t      ctrl,
    output seq_state_e state,
    output logic       halted
);

    logic [3:0] fetch_op;
    logic [3:0] exec_op;
    seq_state_e nxt;

    // Words wider than the opcode field decode as NOP when upper bits are set
    if (W == 4) begin : g_exact
        assign fetch_op = mem_word[3:0];
        assign exec_op  = ir_word[3:0];
    end else begin : g_wide
        assign fetch_op = (mem_word[W-1:4] == '0) ? mem_word[3:0] : 4'(OP_NOP);
        assign exec_op  = (ir_word[W-1:4]  == '0) ? ir_word[3:0]  : 4'(OP_NOP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        ctrl = '0;
        nxt  = state;
        if (!prog_en) begin
            unique case (state)
                ST_FETCH: begin
                    ctrl.ir_load = 1'b1;
                    ctrl.pc_inc  = 1'b1;
                    nxt = needs_operand(fetch_op) ? ST_OPER : ST_EXEC;
                end
                ST_OPER: begin
                    ctrl.opr_load = 1'b1;
                    ctrl.pc_inc   = 1'b1;
                    nxt = ST_EXEC;
                end
                ST_EXEC: begin
                    ctrl.addr_opr = 1'b1;
                    nxt = ST_FETCH;
                    case (exec_op)
                        OP_LDA:    ctrl.a_from_mem = 1'b1;
                        OP_ADD:    ctrl.a_add      = 1'b1;
                        OP_STA:    ctrl.mem_we     = 1'b1;
                        OP_JMP:    ctrl.pc_jump    = 1'b1;
                        OP_HLT:    nxt             = ST_HALT;
                        OP_MOVB:   ctrl.b_from_a   = 1'b1;
                        OP_MOVOUT: ctrl.out_from_a = 1'b1;
                        default:   ;
                    endcase
                end
                ST_HALT: begin
                    nxt = ST_HALT;
                end
            endcase
        end
    end

    always_comb begin
        halted = (state == ST_HALT);
    end

endmodule

// File: rtl/nib_dp.sv
module nib_dp
    import nib_cpu_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ctrl_t        ctrl,
    input  logic [W-1:0] mem_word,
    output logic [W-1:0] pc,
    output logic [W-1:0] ir,
    output logic [W-1:0] opr,
    output logic [W-1:0] a,
    output logic [W-1:0] b,
    output logic [W-1:0] out
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc  <= '0;
            ir  <= '0;
            opr <= '0;
        end else begin
            if (ctrl.pc_jump) begin
                pc <= opr;
            end else if (ctrl.pc_inc) begin
                pc <= pc + W'(1);
            end
            if (ctrl.ir_load) begin
                ir <= mem_word;
            end
            if (ctrl.opr_load) begin
                opr <= mem_word;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a   <= '0;
            b   <= '0;
            out <= '0;
        end else begin
            if (ctrl.a_from_mem) begin
                a <= mem_word;
            end else if (ctrl.a_add) begin
                a <= a + b;
            end
            if (ctrl.b_from_a) begin
                b <= a;
            end
            if (ctrl.out_from_a) begin
                out <= a;
            end
        end
    end

endmodule

// File: rtl/nib_cpu.sv
module nib_cpu
    import nib_cpu_pkg::*;
#(
    parameter int WORD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic [WORD_W-1:0] prog_addr,
    input  logic [WORD_W-1:0] prog_data,
    input  logic              prog_we,
    output logic [WORD_W-1:0] out_val,
    output logic              halted
);

    localparam int DEPTH = 2 ** WORD_W;

    ctrl_t             ctrl;
    seq_state_e        state_q;
    logic [WORD_W-1:0] pc_q, ir_q, opr_q, a_q, b_q;
    logic [WORD_W-1:0] mem_rdata, mem_raddr;
    logic [WORD_W-1:0] mem_waddr, mem_wdata;
    logic              mem_we;

    assign mem_raddr = ctrl.addr_opr ? opr_q : pc_q;
    assign mem_we    = prog_en ? prog_we   : ctrl.mem_we;
    assign mem_waddr = prog_en ? prog_addr : opr_q;
    assign mem_wdata = prog_en ? prog_data : a_q;

    nib_ram #(.W(WORD_W), .DEPTH(DEPTH)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    nib_seq #(.W(WORD_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .prog_en  (prog_en),
        .mem_word (mem_rdata),
        .ir_word  (ir_q),
        .ctrl     (ctrl),
        .state    (state_q),
        .halted   (halted)
    );

    nib_dp #(.W(WORD_W)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl     (ctrl),
        .mem_word (mem_rdata),
        .pc       (pc_q),
        .ir       (ir_q),
        .opr      (opr_q),
        .a        (a_q),
        .b        (b_q),
        .out      (out_val)
    );

endmodule

// File: rtl/nib_cpu_chk.sv
module nib_cpu_chk
    import nib_cpu_pkg::*;
#(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         prog_en,
    input logic         halted,
    input logic [W-1:0] out_val,
    input logic [W-1:0] pc,
    input logic [W-1:0] ir,
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input seq_state_e   state
);

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R8

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> ($stable(out_val) && $stable(pc))); // R8

    AST_PROG_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_en |=> ($stable(pc) && $stable(a) && $stable(b) && $stable(out_val))); // R9

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_en && (state == ST_FETCH || state == ST_OPER)) |=> (pc == W'($past(pc) + W'(1)))); // R6

    AST_IR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_en || state != ST_FETCH) |=> $stable(ir)); // R6

    AST_ADD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_en && state == ST_EXEC && ir == W'(OP_ADD)) |=> (a == W'($past(a) + $past(b)))); // R3

endmodule

bind nib_cpu nib_cpu_chk #(.W(WORD_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .prog_en (prog_en),
    .halted  (halted),
    .out_val (out_val),
    .pc      (pc_q),
    .ir      (ir_q),
    .a       (a_q),
    .b       (b_q),
    .state   (state_q)
);

// File: tb/nib_cpu_test.sv
`timescale 1ns/1ps
module nib_cpu_test;

    typedef logic [3:0] img_t [16];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       prog_en = 1'b1;
    logic [3:0] prog_addr = '0;
    logic [3:0] prog_data = '0;
    logic       prog_we = 1'b0;
    logic [3:0] out_val;
    logic       halted;

    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    int    exp_q[$];
    string tag_q[$];
    logic [3:0] prev_out = '0;

    nib_cpu uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_en),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .prog_we   (prog_we),
        .out_val   (out_val),
        .halted    (halted)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push_expect(input int v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    // Monitor: every change of the output is compared with the next queued item
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_out = 4'd0;
        end else if (out_val !== prev_out) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected output change", int'(out_val), -1);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_val == 4'(e), t, int'(out_val), e);
            end
            prev_out = out_val;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected halt", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    task automatic load_and_start(input img_t im);
        @(negedge clk);
        rst_n   = 1'b0;
        prog_en = 1'b1;
        @(negedge clk);
        check(out_val == 4'd0 && !halted, "R10 reset clears", int'(out_val), 0);
        for (int i = 0; i < 16; i++) begin
            prog_addr = 4'(i);
            prog_data = im[i];
            prog_we   = 1'b1;
            @(negedge clk);
        end
        prog_we = 1'b0;
        rst_n   = 1'b1;
        @(negedge clk);
        check(out_val == 4'd0 && !halted, "R1 reset state", int'(out_val), 0);
        prog_en = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        for (int i = 0; i < 200; i++) begin
            if (halted) break;
            @(negedge clk);
        end
        check(halted == 1'b1, tag, int'(halted), 1);
        @(negedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    img_t p_sum  = '{4'h1, 4'h8, 4'h6, 4'h1, 4'h9, 4'h2, 4'h7, 4'h5,
                     4'h5, 4'h3, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0};
    img_t p_wrap = '{4'h0, 4'h1, 4'hD, 4'h6, 4'h2, 4'h7, 4'h5, 4'h0,
                     4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h9, 4'h0, 4'h0};
    img_t p_jump = '{4'h1, 4'hF, 4'h3, 4'hE, 4'h8, 4'h4, 4'h8, 4'h7,
                     4'h1, 4'hE, 4'h6, 4'h2, 4'h7, 4'h5, 4'h0, 4'h6};
    img_t p_pcw  = '{4'h4, 4'hF, 4'h7, 4'h5, 4'h9, 4'h0, 4'h0, 4'h0,
                     4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h1};

    initial begin
        // R2 sample program, with an R9 freeze partway through
        load_and_start(p_sum);
        push_expect(8, "R2 R11 sum output");
        repeat (4) @(negedge clk);
        prog_en = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (i == 19) begin
                check(!halted, "R9 frozen not halted", int'(halted), 0);
                check(out_val == 4'd0, "R9 frozen output", int'(out_val), 0);
            end
        end
        prog_en = 1'b0;
        wait_done("R2 halt");
        repeat (20) @(negedge clk);
        check(out_val == 4'd8 && halted, "R8 halt frozen", int'(out_val), 8);

        // R3 carry dropped, R7 NOP 0000
        load_and_start(p_wrap);
        push_expect(2, "R3 R7 add modulo 16");
        wait_done("R3 halt");

        // R4 store/load, R5 jump skips trap, R7 code 1000
        load_and_start(p_jump);
        push_expect(12, "R4 R5 R7 store jump");
        wait_done("R5 halt");

        // R10 reset while halted keeps RAM (stored word still read back)
        @(negedge clk);
        rst_n = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        check(out_val == 4'd0 && !halted, "R10 reset while halted", int'(out_val), 0);
        rst_n = 1'b1;
        push_expect(12, "R10 RAM kept");
        wait_done("R10 halt");

        // R6 operand fetch wraps 1111 to 0000, R7 code 1111
        load_and_start(p_pcw);
        push_expect(9, "R6 R7 operand wrap");
        wait_done("R6 halt");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule